// File: doc/BRIEF.md
# Multiprocessor-Addressable Serial Port

This block is a full-duplex asynchronous serial port. Bytes written into an eight-entry transmit queue are sent on `txd` as frames; frames arriving on `rxd` are decoded, checked, and placed in an eight-entry receive queue. Each received entry carries its own error flags. The bit rate is set by a divisor. A 16x oversampling tick is produced every `cfg_div+1` clock cycles, so one bit lasts `16*(cfg_div+1)` cycles.

A frame is one low start bit, eight data bits sent least significant bit first, an optional ninth bit and one high stop bit. The ninth bit is present when parity is on or when multiprocessor mode is on. In multiprocessor mode the ninth bit marks an address frame, and parity is not used. Several nodes can then share one pair of lines. The receiver keeps only the traffic addressed to its own node address.

Top module: `uart_mp`

## Requirements
- R1: With `cfg_div` = D, every transmitted bit lasts exactly 16*(D+1) clock cycles.
- R2: An idle `txd` is high. A frame is a 0 start bit, then data bits 0..7 in that order, then the ninth bit if it is enabled, then a 1 stop bit.
- R3: When parity is on (`cfg_par_en`=1, `cfg_mp_en`=0), the ninth transmitted bit is the XOR of the eight data bits, inverted when `cfg_par_odd`=1.
- R4: The receive queue holds 8 entries and returns them in arrival order. A frame that arrives while the queue is full is dropped and sets `rx_ovf`, which stays set until reset.
- R5: A start bit is taken only if `rxd` is still low at mid-bit. A low pulse shorter than half a bit stores nothing.
- R6: A received frame with correct format is stored with its eight data bits on `rx_data`, its ninth bit on `rx_ninth`, and all error flags clear.
- R7: With parity on, `rx_perr` is set on an entry whose ninth bit does not match the even or odd rule of R3.
- R8: A stop bit sampled low, in a frame that is not a break, sets `rx_ferr`.
- R9: A frame whose data bits, ninth bit (if present) and stop bit are all low sets `rx_brk` and leaves `rx_ferr` clear. The receiver then waits for `rxd` to go high before it looks for a new start bit.
- R10: In multiprocessor mode, an address frame (ninth bit 1) selects the node when its data equals `cfg_addr`, and deselects it otherwise. A matching address frame is stored, a non-matching one is not, and data frames (ninth bit 0) are stored only while the node is selected.
- R11: In multiprocessor mode, `tx_data[8]` is sent as the ninth bit.
- R12: After reset, `txd` is 1, `rx_empty` is 1, `tx_full` is 0 and `rx_ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Oversampling tick divisor minus one |
| cfg_par_en | input | 1 | Parity enable (ignored in multiprocessor mode) |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_mp_en | input | 1 | Multiprocessor addressing mode |
| cfg_addr | input | 8 | Node address in multiprocessor mode |
| tx_wr | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 9 | Byte to send; bit 8 is the address flag in multiprocessor mode |
| tx_full | output | 1 | Transmit queue full |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_rd | input | 1 | Pop the head of the receive queue |
| rx_data | output | 8 | Head entry data byte |
| rx_ninth | output | 1 | Head entry ninth bit |
| rx_perr | output | 1 | Head entry parity error |
| rx_ferr | output | 1 | Head entry frame error |
| rx_brk | output | 1 | Head entry break |
| rx_empty | output | 1 | Receive queue empty |
| rx_ovf | output | 1 | Sticky receive overflow |

## Verification
The bench uses the default queue depth of 8 and `DIV_W` of 12, and drives `cfg_div` = 3. That makes a bit 64 cycles long, so dozens of random frames in every parity mode fit in the run, and a bit length can be measured exactly. With a depth of 8, nine frames sent back to back reach the overflow case. Directed frames cover a short start glitch, a frame error, a break, and an address sequence that selects the node and then deselects it.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;
  localparam int unsigned OVS   = 16;
  localparam int unsigned OVS_W = $clog2(OVS);

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_err_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_HOLD} rx_state_t;
endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q >= div);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_wr, do_rd;

  assign full  = (cnt_q == (AW+1)'(DEPTH));
  assign empty = (cnt_q == '0);
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;
  assign rdata = mem[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_wr) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    if (do_rd) rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    if (do_wr && !do_rd) cnt_d = cnt_q + 1'b1;
    else if (do_rd && !do_wr) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q] <= wdata;
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_mp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       mp_en,
  input  logic       q_empty,
  input  logic [8:0] q_data,
  output logic       q_pop,
  output logic       txd
);
  logic             busy_q, busy_d;
  logic [10:0]      sh_q, sh_d;
  logic [3:0]       bitn_q, bitn_d;
  logic [OVS_W-1:0] tcnt_q, tcnt_d;
  logic             nine, ninth;
  logic [3:0]       last;

  assign nine  = mp_en || par_en;
  assign ninth = mp_en ? q_data[8] : ((^q_data[7:0]) ^ par_odd);
  assign last  = nine ? 4'd10 : 4'd9;
  assign txd   = busy_q ? sh_q[0] : 1'b1;

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    bitn_d = bitn_q;
    tcnt_d = tcnt_q;
    q_pop  = 1'b0;
    if (tick) begin
      if (!busy_q) begin
        if (!q_empty) begin
          busy_d = 1'b1;
          q_pop  = 1'b1;
          sh_d   = {1'b1, (nine ? ninth : 1'b1), q_data[7:0], 1'b0};
          bitn_d = '0;
          tcnt_d = '0;
        end
      end else if (tcnt_q == OVS_W'(OVS - 1)) begin
        tcnt_d = '0;
        sh_d   = {1'b1, sh_q[10:1]};
        if (bitn_q == last) busy_d = 1'b0;
        else                bitn_d = bitn_q + 1'b1;
      end else begin
        tcnt_d = tcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      bitn_q <= '0;
      tcnt_q <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      bitn_q <= bitn_d;
      tcnt_q <= tcnt_d;
    end
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_mp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       mp_en,
  output logic       frm_valid,
  output logic [7:0] frm_data,
  output logic       frm_ninth,
  output rx_err_t    frm_err
);
  rx_state_t        st_q, st_d;
  logic [OVS_W-1:0] tcnt_q, tcnt_d;
  logic [3:0]       bitn_q, bitn_d;
  logic [8:0]       sh_q, sh_d;
  logic             val_d;
  rx_err_t          err_d;
  logic             nine, all_low;
  logic [3:0]       ndat;

  assign nine    = mp_en || par_en;
  assign ndat    = nine ? 4'd9 : 4'd8;
  assign all_low = (sh_q[7:0] == 8'h00) && !(nine && sh_q[8]);

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    bitn_d = bitn_q;
    sh_d   = sh_q;
    val_d  = 1'b0;
    err_d  = '0;
    case (st_q)
      RX_IDLE:
        if (tick && !rx) begin
          st_d   = RX_START;
          tcnt_d = '0;
        end
      RX_START:
        if (tick) begin
          if (tcnt_q == OVS_W'(OVS/2 - 1)) begin
            tcnt_d = '0;
            bitn_d = '0;
            sh_d   = '0;
            st_d   = rx ? RX_IDLE : RX_DATA;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      RX_DATA:
        if (tick) begin
          if (tcnt_q == OVS_W'(OVS - 1)) begin
            tcnt_d = '0;
            if (bitn_q != ndat) begin
              sh_d[bitn_q] = rx;
              bitn_d       = bitn_q + 1'b1;
            end else begin
              val_d     = 1'b1;
              err_d.brk = !rx && all_low;
              err_d.frm = !rx && !all_low;
              err_d.par = par_en && !mp_en && !(!rx && all_low) &&
                          ((^sh_q) ^ par_odd);
              st_d      = rx ? RX_IDLE : RX_HOLD;
            end
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      default:
        if (rx) st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= RX_IDLE;
      tcnt_q    <= '0;
      bitn_q    <= '0;
      sh_q      <= '0;
      frm_valid <= 1'b0;
      frm_err   <= '0;
    end else begin
      st_q      <= st_d;
      tcnt_q    <= tcnt_d;
      bitn_q    <= bitn_d;
      sh_q      <= sh_d;
      frm_valid <= val_d;
      frm_err   <= err_d;
    end
  end

  assign frm_data  = sh_q[7:0];
  assign frm_ninth = nine ? sh_q[8] : 1'b0;
endmodule

// File: rtl/uart_mp.sv
module uart_mp
  import uart_mp_pkg::*;
#(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_mp_en,
  input  logic [7:0]       cfg_addr,
  input  logic             tx_wr,
  input  logic [8:0]       tx_data,
  output logic             tx_full,
  output logic             txd,
  input  logic             rxd,
  input  logic             rx_rd,
  output logic [7:0]       rx_data,
  output logic             rx_ninth,
  output logic             rx_perr,
  output logic             rx_ferr,
  output logic             rx_brk,
  output logic             rx_empty,
  output logic             rx_ovf
);
  localparam int unsigned RXW = 9 + $bits(rx_err_t);

  logic       tick;
  logic       txq_empty, txq_pop;
  logic [8:0] txq_data;
  logic       rx_s1, rx_s2;
  logic       frm_valid, frm_ninth;
  logic [7:0] frm_data;
  rx_err_t    frm_err;
  logic       sel_q, sel_d, ovf_d;
  logic       rx_push, rx_full_i;
  logic [RXW-1:0] rxq_out;

  uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick)
  );

  uart_fifo #(.W(9), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .wr(tx_wr), .wdata(tx_data),
    .rd(txq_pop), .rdata(txq_data), .full(tx_full), .empty(txq_empty)
  );

  uart_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .par_en(cfg_par_en),
    .par_odd(cfg_par_odd), .mp_en(cfg_mp_en), .q_empty(txq_empty),
    .q_data(txq_data), .q_pop(txq_pop), .txd(txd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
    end
  end

  uart_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s2),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .mp_en(cfg_mp_en),
    .frm_valid(frm_valid), .frm_data(frm_data), .frm_ninth(frm_ninth),
    .frm_err(frm_err)
  );

  // address filter and overflow tracking
  always_comb begin
    sel_d   = sel_q;
    rx_push = 1'b0;
    if (frm_valid) begin
      if (!cfg_mp_en) begin
        rx_push = 1'b1;
      end else if (frm_ninth) begin
        sel_d   = (frm_data == cfg_addr);
        rx_push = sel_d;
      end else begin
        rx_push = sel_q;
      end
    end
    ovf_d = rx_ovf || (rx_push && rx_full_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      rx_ovf <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      rx_ovf <= ovf_d;
    end
  end

  uart_fifo #(.W(RXW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .wr(rx_push),
    .wdata({frm_err, frm_ninth, frm_data}),
    .rd(rx_rd), .rdata(rxq_out), .full(rx_full_i), .empty(rx_empty)
  );

  assign rx_data  = rxq_out[7:0];
  assign rx_ninth = rxq_out[8];
  assign rx_perr  = rxq_out[9];
  assign rx_ferr  = rxq_out[10];
  assign rx_brk   = rxq_out[11];
endmodule

// File: rtl/uart_mp_chk.sv
module uart_mp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_par_en,
  input logic       cfg_mp_en,
  input logic [7:0] cfg_addr,
  input logic       frm_valid,
  input logic [7:0] frm_data,
  input logic       frm_ninth,
  input logic       frm_brk,
  input logic       frm_frm,
  input logic       frm_par,
  input logic       rx_push,
  input logic       rx_full_i,
  input logic       rx_empty,
  input logic       rx_ovf,
  input logic       txd,
  input logic       tx_busy
);
  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_ovf) |-> rx_ovf);

  assert_ovf_on_full_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full_i) |=> rx_ovf);

  assert_fill_needs_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_empty) |-> $past(rx_push));

  assert_break_not_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> !(frm_brk && frm_frm));

  assert_parity_only_when_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_par) |-> (cfg_par_en && !cfg_mp_en));

  assert_addr_store_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && cfg_mp_en && frm_ninth) |-> (frm_data == cfg_addr));

  assert_push_needs_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> frm_valid);

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
endmodule

bind uart_mp uart_mp_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_par_en(cfg_par_en), .cfg_mp_en(cfg_mp_en),
  .cfg_addr(cfg_addr), .frm_valid(frm_valid), .frm_data(frm_data),
  .frm_ninth(frm_ninth), .frm_brk(frm_err.brk), .frm_frm(frm_err.frm),
  .frm_par(frm_err.par), .rx_push(rx_push), .rx_full_i(rx_full_i),
  .rx_empty(rx_empty), .rx_ovf(rx_ovf), .txd(txd), .tx_busy(u_tx.busy_q)
);

// File: tb/test_uart_mp.sv
module test_uart_mp;
  localparam int DIV_W = 12;
  localparam int DIVV  = 3;
  localparam int BITC  = 16 * (DIVV + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0] cfg_div = DIV_W'(DIVV);
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_mp_en = 1'b0;
  logic [7:0] cfg_addr = 8'h00;
  logic tx_wr = 1'b0;
  logic [8:0] tx_data = '0;
  logic tx_full, txd;
  logic rxd = 1'b1;
  logic rx_rd = 1'b0;
  logic [7:0] rx_data;
  logic rx_ninth, rx_perr, rx_ferr, rx_brk, rx_empty, rx_ovf;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_mp #(.DIV_W(DIV_W), .DEPTH(8)) i_uart_mp (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_mp_en(cfg_mp_en), .cfg_addr(cfg_addr),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full), .txd(txd),
    .rxd(rxd), .rx_rd(rx_rd), .rx_data(rx_data), .rx_ninth(rx_ninth),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .rx_empty(rx_empty), .rx_ovf(rx_ovf)
  );

  function automatic logic par_bit(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  task automatic drive_bit(input logic b);
    @(negedge clk) rxd = b;
    repeat (BITC - 1) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic nb, input bit nine, input logic stopv);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (nine) drive_bit(nb);
    drive_bit(stopv);
    @(negedge clk) rxd = 1'b1;
    repeat (BITC / 2) @(negedge clk);
  endtask

  task automatic read_check(input string req, input logic [7:0] d, input logic nb,
                            input logic pe, input logic fe, input logic be);
    @(negedge clk);
    chk(!rx_empty, req, rx_empty, 0);
    chk(rx_data == d, req, rx_data, d);
    chk(rx_ninth == nb, req, rx_ninth, nb);
    chk({rx_brk, rx_ferr, rx_perr} == {be, fe, pe}, req,
        {rx_brk, rx_ferr, rx_perr}, {be, fe, pe});
    rx_rd = 1'b1;
    @(negedge clk) rx_rd = 1'b0;
  endtask

  task automatic tx_check(input string req, input logic [8:0] d, input bit nine,
                          input logic nb);
    tx_data = d;
    tx_wr = 1'b1;
    @(negedge clk) tx_wr = 1'b0;
    while (txd) @(negedge clk);
    repeat (BITC / 2) @(negedge clk);
    chk(txd == 1'b0, {req, " start"}, txd, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (BITC) @(negedge clk);
      chk(txd == d[i], {req, " data"}, txd, d[i]);
    end
    if (nine) begin
      repeat (BITC) @(negedge clk);
      chk(txd == nb, {req, " ninth"}, txd, nb);
    end
    repeat (BITC) @(negedge clk);
    chk(txd == 1'b1, {req, " stop"}, txd, 1);
    repeat (BITC) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(txd == 1'b1, "R12 txd", txd, 1);
    chk(rx_empty == 1'b1, "R12 rx_empty", rx_empty, 1);
    chk(tx_full == 1'b0, "R12 tx_full", tx_full, 0);
    chk(rx_ovf == 1'b0, "R12 rx_ovf", rx_ovf, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 bit length: data bit0 = 1, so the start bit is a single low bit
    begin
      int len = 0;
      tx_data = 9'h0FF;
      tx_wr = 1'b1;
      @(negedge clk) tx_wr = 1'b0;
      while (txd) @(negedge clk);
      while (!txd) begin
        len++;
        @(negedge clk);
      end
      chk(len == BITC, "R1 bit length", len, BITC);
      repeat (10 * BITC) @(negedge clk);
    end

    // R2 / R3 transmit frames, random bytes in each parity mode
    for (int k = 0; k < 6; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      cfg_par_en = k[0] | k[1];
      cfg_par_odd = k[1];
      if (cfg_par_en) tx_check("R3 parity frame", {1'b0, d}, 1, par_bit(d, cfg_par_odd));
      else            tx_check("R2 plain frame", {1'b0, d}, 0, 1'b0);
    end

    // R6 receive random frames, random parity mode
    for (int k = 0; k < 20; k++) begin
      logic [7:0] d;
      logic pe, po, nb;
      d  = 8'($urandom);
      pe = 1'($urandom);
      po = 1'($urandom);
      cfg_par_en = pe;
      cfg_par_odd = po;
      nb = pe ? par_bit(d, po) : 1'b0;
      send(d, nb, pe, 1'b1);
      read_check("R6 receive", d, nb, 0, 0, 0);
    end

    // R7 parity error, even and odd
    cfg_par_en = 1; cfg_par_odd = 0;
    send(8'h0F, 1'b1, 1, 1'b1);
    read_check("R7 even parity error", 8'h0F, 1'b1, 1, 0, 0);
    cfg_par_odd = 1;
    send(8'h07, 1'b1, 1, 1'b1);
    read_check("R7 odd parity error", 8'h07, 1'b1, 1, 0, 0);
    cfg_par_en = 0; cfg_par_odd = 0;

    // R8 frame error
    send(8'h55, 1'b0, 0, 1'b0);
    read_check("R8 frame error", 8'h55, 1'b0, 0, 1, 0);

    // R9 break: all low, then a normal frame must still be received
    send(8'h00, 1'b0, 0, 1'b0);
    read_check("R9 break", 8'h00, 1'b0, 0, 0, 1);
    send(8'hC3, 1'b0, 0, 1'b1);
    read_check("R9 after break", 8'hC3, 1'b0, 0, 0, 0);

    // R5 short low glitch stores nothing
    @(negedge clk) rxd = 1'b0;
    repeat (BITC / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * BITC) @(negedge clk);
    chk(rx_empty == 1'b1, "R5 glitch ignored", rx_empty, 1);

    // R4 depth and overflow
    for (int k = 0; k < 8; k++) send(8'(k + 8'h30), 1'b0, 0, 1'b1);
    chk(rx_ovf == 1'b0, "R4 no overflow at 8", rx_ovf, 0);
    send(8'hEE, 1'b0, 0, 1'b1);
    chk(rx_ovf == 1'b1, "R4 overflow set", rx_ovf, 1);
    for (int k = 0; k < 8; k++) read_check("R4 order", 8'(k + 8'h30), 1'b0, 0, 0, 0);
    @(negedge clk);
    chk(rx_empty == 1'b1, "R4 ninth dropped", rx_empty, 1);
    chk(rx_ovf == 1'b1, "R4 overflow sticky", rx_ovf, 1);

    // R10 multiprocessor filtering
    cfg_mp_en = 1; cfg_addr = 8'h5A;
    send(8'h10, 1'b0, 1, 1'b1);
    send(8'h33, 1'b1, 1, 1'b1);
    send(8'h5A, 1'b1, 1, 1'b1);
    send(8'h21, 1'b0, 1, 1'b1);
    send(8'h11, 1'b1, 1, 1'b1);
    send(8'h22, 1'b0, 1, 1'b1);
    read_check("R10 matching address", 8'h5A, 1'b1, 0, 0, 0);
    read_check("R10 selected data", 8'h21, 1'b0, 0, 0, 0);
    @(negedge clk);
    chk(rx_empty == 1'b1, "R10 deselected dropped", rx_empty, 1);

    // R11 address flag transmitted
    tx_check("R11 address flag", 9'h1A5, 1, 1'b1);
    tx_check("R11 data flag", 9'h03C, 1, 1'b0);

    finish_run();
  end
endmodule